// File: doc/BRIEF.md
# Status and Translation Control Registers

This block keeps the machine status word, a restricted supervisor window onto that word, the address-translation control word and the floating-point flag and rounding registers for a 64-bit core that has user, supervisor and machine privilege. An instruction-decode stage hands it one CSR write per cycle (address, data, current privilege). Reads are combinational by address. The block filters every write field by field. When a write alters how virtual addresses are translated, it produces a one-cycle flush request for the translation caches. A separate flag marks accesses that must raise an illegal-instruction trap.

The translation word holds a mode nibble, an address-space identifier (ASID) and a root page number. This block never keeps an ASID. In 64-bit form it accepts only the two paging modes it supports. Any other mode code is dropped without a trace. A dedicated width input sets the user and supervisor width fields. It also selects between the 64-bit and 32-bit layouts of the translation word.

Top module: `xlat_status_regs`

## Requirements
- R1: After reset the status word reads 0x0000_000A_0000_0000 (both width fields = 2, meaning 64-bit, every other bit 0). The translation word, fflags, frm, the illegal flag and the flush output are all 0.
- R2: A write to the machine status address (0x300) updates only these fields and ignores all other bits: 0,1,3,4,5,7,8,11,12,13–14 (FP state), 15–16 (extension state), 17 (modify-privilege, MPRV), 18 (SUM), 19 (MXR), 20 (trap-VM, TVM), 21 and 22. Bits 6, 36 and 37 (byte-order) always read 0. Bits 33:32 and 35:34 (width fields) cannot be changed by a status write.
- R3: The supervisor window (0x100) reads the status word masked to bits 0,1,4,5,8,13–16,18,19,33:32 and 63. A write through the window changes only bits 0,1,4,5,8,13–16,18 and 19.
- R4: Status bit 63 reads 1 exactly when bits 14:13 equal 2'b11 or bits 16:15 equal 2'b11. Writing bit 63 has no effect.
- R5: The flush output is high for exactly one cycle, the cycle after a status write (either address) that changes bit 17, 18 or 19, or that changes bits 12:11 while the old bit 17 was 1. Any other status write leaves it low.
- R6: In the 64-bit layout, a write to the translation word (0x180) stores bits 59:44 as 0. In the 32-bit layout it stores bits 30:22 and 63:32 as 0.
- R7: In the 64-bit layout, a translation write whose bits 63:60 are neither 8 nor 9 leaves the word unchanged and raises no flush. An accepted write that changes the stored value pulses flush the next cycle. An accepted write that leaves the value equal does not.
- R8: With privilege 2'b01 (supervisor) and status bit 20 set, a translation write that would change the stored value raises the illegal flag in its own cycle. The value stays unchanged and no flush is raised. A translation read (rd_en) in that condition also raises the flag. A write of an equal value does not.
- R9: fflags (0x001) is 5 bits and frm (0x002) is 3 bits. fcsr (0x003) reads {frm, fflags} in bits 7:0, and writing it loads frm from bits 7:5 and fflags from bits 4:0. A write to any of the three sets status bits 14:13 to 2'b11 and raises no flush.
- R10: A width_wr pulse loads width_code into both width fields. When width_code is 1 (32-bit), the translation word uses the 32-bit layout: any mode is accepted, and the mode bit is bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CSR write request |
| wr_addr | input | 12 | CSR write address |
| wr_data | input | 64 | CSR write data |
| cur_priv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| rd_en | input | 1 | CSR read request, used only for the illegal check |
| rd_addr | input | 12 | CSR read address |
| rd_data | output | 64 | Combinational read data (0 for unknown addresses) |
| width_wr | input | 1 | Load the width fields |
| width_code | input | 2 | Width code (1 = 32-bit, 2 = 64-bit) |
| illegal | output | 1 | The current access must trap as illegal |
| xlat_flush | output | 1 | Registered translation flush pulse |

## Verification
The block has no sizing parameters, so the bench uses the default address assignment. That configuration is already small enough to cover exhaustively. A Gray-code walk over MPRV, SUM, MXR and the two previous-privilege bits reaches every single-field transition, in both states of MPRV. All 16 translation mode codes are tried under every privilege, with TVM both clear and set, and each is written twice to separate changing writes from equal writes. Switching the width input to 32-bit makes the alternate translation layout reachable.

// File: rtl/xlat_status_regs.sv
module xlat_status_regs #(
  parameter logic [11:0] A_FFLAGS = 12'h001,
  parameter logic [11:0] A_FRM    = 12'h002,
  parameter logic [11:0] A_FCSR   = 12'h003,
  parameter logic [11:0] A_SSTAT  = 12'h100,
  parameter logic [11:0] A_XLAT   = 12'h180,
  parameter logic [11:0] A_MSTAT  = 12'h300
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [11:0] wr_addr,
  input  logic [63:0] wr_data,
  input  logic [1:0]  cur_priv,
  input  logic        rd_en,
  input  logic [11:0] rd_addr,
  output logic [63:0] rd_data,
  input  logic        width_wr,
  input  logic [1:0]  width_code,
  output logic        illegal,
  output logic        xlat_flush
);
  localparam int B_UIE = 0, B_SIE = 1, B_MIE = 3, B_UPIE = 4, B_SPIE = 5, B_MPIE = 7;
  localparam int B_SPP = 8, B_MPP = 11, B_FS = 13, B_XS = 15, B_MPRV = 17, B_SUM = 18;
  localparam int B_MXR = 19, B_TVM = 20, B_TW = 21, B_TSR = 22, B_UXL = 32, B_SXL = 34, B_SD = 63;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] WIDTH64 = 2'd2;

  localparam logic [63:0] ONE = 64'd1;
  localparam logic [63:0] M_SWR = (ONE << B_UIE) | (ONE << B_SIE) | (ONE << B_UPIE) | (ONE << B_SPIE)
                                | (ONE << B_SPP) | (64'd3 << B_FS) | (64'd3 << B_XS)
                                | (ONE << B_SUM) | (ONE << B_MXR);
  localparam logic [63:0] M_MWR = M_SWR | (ONE << B_MIE) | (ONE << B_MPIE) | (64'd3 << B_MPP)
                                | (ONE << B_MPRV) | (ONE << B_TVM) | (ONE << B_TW) | (ONE << B_TSR);
  localparam logic [63:0] M_SRD = M_SWR | (64'd3 << B_UXL) | (ONE << B_SD);
  localparam logic [63:0] M_XL  = (ONE << B_MPRV) | (ONE << B_SUM) | (ONE << B_MXR);
  localparam logic [63:0] ASID64 = 64'hFFFF << 44;
  localparam logic [31:0] ASID32 = 32'h1FF << 22;

  logic [63:0] st_q, satp_q;
  logic [1:0]  uxl_q, sxl_q;
  logic [4:0]  ff_q;
  logic [2:0]  frm_q;

  logic        sd, we_m, we_s, we_fp, we_at, st_flush;
  logic        is64, at_diff, tvm_trap, at_ill, at_mode_ok, at_take;
  logic [63:0] stat_rd, st_new, st_chg, at_val;

  assign sd      = (&st_q[B_FS+1:B_FS]) | (&st_q[B_XS+1:B_XS]);
  assign stat_rd = st_q | (64'(uxl_q) << B_UXL) | (64'(sxl_q) << B_SXL) | (64'(sd) << B_SD);

  assign we_m  = wr_en && wr_addr == A_MSTAT;
  assign we_s  = wr_en && wr_addr == A_SSTAT;
  assign we_fp = wr_en && (wr_addr == A_FFLAGS || wr_addr == A_FRM || wr_addr == A_FCSR);
  assign we_at = wr_en && wr_addr == A_XLAT;

  assign st_new   = we_m ? (wr_data & M_MWR) : ((st_q & ~M_SWR) | (wr_data & M_SWR));
  assign st_chg   = st_q ^ st_new;
  assign st_flush = (we_m || we_s) &&
                    ((|(st_chg & M_XL)) || (st_q[B_MPRV] && |st_chg[B_MPP+1:B_MPP]));

  assign is64       = sxl_q == WIDTH64;
  assign at_val     = is64 ? (wr_data & ~ASID64) : {32'b0, wr_data[31:0] & ~ASID32};
  assign at_diff    = at_val != satp_q;
  assign tvm_trap   = cur_priv == PRIV_S && st_q[B_TVM];
  assign at_ill     = we_at && at_diff && tvm_trap;
  assign at_mode_ok = !is64 || at_val[63:60] == 4'd8 || at_val[63:60] == 4'd9;
  assign at_take    = we_at && at_diff && !tvm_trap && at_mode_ok;

  assign illegal = at_ill || (rd_en && rd_addr == A_XLAT && tvm_trap);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= '0;
      uxl_q      <= WIDTH64;
      sxl_q      <= WIDTH64;
      satp_q     <= '0;
      ff_q       <= '0;
      frm_q      <= '0;
      xlat_flush <= 1'b0;
    end else begin
      xlat_flush <= st_flush || at_take;
      if (we_m || we_s) st_q <= st_new;
      if (we_fp) begin
        st_q[B_FS+1:B_FS] <= 2'b11;
        if (wr_addr == A_FFLAGS) ff_q <= wr_data[4:0];
        else if (wr_addr == A_FRM) frm_q <= wr_data[2:0];
        else begin
          frm_q <= wr_data[7:5];
          ff_q  <= wr_data[4:0];
        end
      end
      if (at_take) satp_q <= at_val;
      if (width_wr) begin
        uxl_q <= width_code;
        sxl_q <= width_code;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_FFLAGS: rd_data = {59'b0, ff_q};
      A_FRM:    rd_data = {61'b0, frm_q};
      A_FCSR:   rd_data = {56'b0, frm_q, ff_q};
      A_SSTAT:  rd_data = stat_rd & M_SRD;
      A_MSTAT:  rd_data = stat_rd;
      A_XLAT:   rd_data = satp_q;
      default:  ;
    endcase
  end
endmodule

// File: rtl/xlat_status_chk.sv
module xlat_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [11:0] wr_addr,
  input logic [11:0] rd_addr,
  input logic [63:0] rd_data,
  input logic        illegal,
  input logic        xlat_flush,
  input logic [63:0] satp_q,
  input logic [63:0] st_q
);
  assert_flush_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_flush |-> $past(wr_en));

  assert_byte_order_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 12'h300) |-> (rd_data[6] == 1'b0 && rd_data[37:36] == 2'b00));

  assert_summary_dirty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 12'h300) |-> (rd_data[63] == ((&rd_data[14:13]) || (&rd_data[16:15]))));

  assert_asid_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    satp_q[59:44] == 16'h0);

  assert_mode_supported_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (satp_q[63:60] == 4'd0 || satp_q[63:60] == 4'd8 || satp_q[63:60] == 4'd9));

  assert_trap_holds_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 12'h180 && illegal) |=> $stable(satp_q));

  assert_fp_write_dirty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == 12'h001 || wr_addr == 12'h002 || wr_addr == 12'h003)) |=> (st_q[14:13] == 2'b11));
endmodule

bind xlat_status_regs xlat_status_chk u_xlat_status_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
  .rd_data(rd_data), .illegal(illegal), .xlat_flush(xlat_flush), .satp_q(satp_q), .st_q(st_q)
);

// File: tb/test_xlat_status_regs.sv
`timescale 1ns/1ps
module test_xlat_status_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [1:0]  cur_priv = 2'd3;
  logic        rd_en = 1'b0;
  logic [11:0] rd_addr = '0;
  logic [63:0] rd_data;
  logic        width_wr = 1'b0;
  logic [1:0]  width_code = 2'd2;
  logic        illegal, xlat_flush;

  int total = 0, fails = 0;

  localparam logic [63:0] MW  = 64'h0000_0000_007F_F9BB;
  localparam logic [63:0] SW  = 64'h0000_0000_000D_E133;
  localparam logic [63:0] SRD = 64'h8000_0003_000D_E133;

  logic [63:0] m_st = '0, m_satp = '0;
  logic [1:0]  m_w = 2'd2;
  logic [4:0]  m_ff = '0;
  logic [2:0]  m_frm = '0;

  xlat_status_regs i_xlat_status_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cur_priv(cur_priv), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .width_wr(width_wr), .width_code(width_code), .illegal(illegal), .xlat_flush(xlat_flush)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_status();
    logic sd;
    sd = (&m_st[14:13]) | (&m_st[16:15]);
    return m_st | (64'(m_w) << 32) | (64'(m_w) << 34) | (64'(sd) << 63);
  endfunction

  task automatic rd_chk(input logic [11:0] a, input logic [63:0] exp, input string tag);
    rd_addr = a;
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic check_all(input string tag);
    rd_chk(12'h300, exp_status(), tag);
    rd_chk(12'h100, exp_status() & SRD, tag);
    rd_chk(12'h180, m_satp, tag);
    rd_chk(12'h001, {59'b0, m_ff}, tag);
    rd_chk(12'h002, {61'b0, m_frm}, tag);
    rd_chk(12'h003, {56'b0, m_frm, m_ff}, tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d, input logic [1:0] p,
                    input string ftag, input string rtag);
    logic [63:0] nst, nsatp, chg, v;
    logic [4:0]  nff;
    logic [2:0]  nfrm;
    logic        eill, efl;
    nst = m_st; nsatp = m_satp; nff = m_ff; nfrm = m_frm; eill = 1'b0; efl = 1'b0;
    if (a == 12'h300) nst = d & MW;
    else if (a == 12'h100) nst = (m_st & ~SW) | (d & SW);
    if (a == 12'h300 || a == 12'h100) begin
      chg = m_st ^ nst;
      efl = ((chg & 64'hE0000) != 0) || (m_st[17] && chg[12:11] != 2'b00);
    end
    if (a == 12'h001 || a == 12'h002 || a == 12'h003) begin
      nst[14:13] = 2'b11;
      if (a == 12'h001) nff = d[4:0];
      else if (a == 12'h002) nfrm = d[2:0];
      else begin nfrm = d[7:5]; nff = d[4:0]; end
    end
    if (a == 12'h180) begin
      v = (m_w == 2'd2) ? (d & ~64'h0FFF_F000_0000_0000) : {32'b0, d[31:0] & ~32'h7FC0_0000};
      if (v != m_satp) begin
        if (p == 2'd1 && m_st[20]) eill = 1'b1;
        else if (m_w != 2'd2 || v[63:60] == 4'd8 || v[63:60] == 4'd9) begin
          efl = 1'b1;
          nsatp = v;
        end
      end
    end
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; cur_priv = p;
    #1;
    chk({ftag, " illegal"}, 64'(illegal), 64'(eill));
    @(negedge clk);
    wr_en = 1'b0; cur_priv = 2'd3;
    chk({ftag, " flush"}, 64'(xlat_flush), 64'(efl));
    m_st = nst; m_satp = nsatp; m_ff = nff; m_frm = nfrm;
    check_all(rtag);
    @(negedge clk);
    chk({ftag, " flush one cycle"}, 64'(xlat_flush), 64'd0);
  endtask

  task automatic rd_ill(input logic [1:0] p, input logic exp);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 12'h180; cur_priv = p;
    #1;
    chk("R8 read illegal", 64'(illegal), 64'(exp));
    rd_en = 1'b0; cur_priv = 2'd3;
  endtask

  task automatic set_width(input logic [1:0] c);
    @(negedge clk);
    width_wr = 1'b1; width_code = c;
    @(negedge clk);
    width_wr = 1'b0;
    m_w = c;
    rd_chk(12'h300, exp_status(), "R10 width fields");
    rd_chk(12'h100, exp_status() & SRD, "R10 width in window");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 illegal", 64'(illegal), 64'd0);
    chk("R1 flush", 64'(xlat_flush), 64'd0);
    rd_chk(12'h300, 64'h0000_000A_0000_0000, "R1 status");
    check_all("R1");

    for (int i = 0; i < 64; i++) begin
      logic [5:0]  g;
      logic [63:0] d;
      g = 6'(i) ^ (6'(i) >> 1);
      d = '0;
      d[17] = g[0]; d[18] = g[1]; d[19] = g[2]; d[11] = g[3]; d[12] = g[4];
      d[6] = 1'b1; d[37:32] = 6'h3F;
      if (g[5]) d[16:13] = 4'hF;
      wr(12'h300, d, 2'd3, "R5 status walk", "R2");
    end
    for (int i = 0; i < 48; i++)
      wr(12'h300, 64'(i + 1) * 64'h9E37_79B9_7F4A_7C15, 2'd3, "R5 status mix", "R2");
    for (int i = 0; i < 48; i++)
      wr(12'h100, 64'(i + 7) * 64'hC2B2_AE3D_27D4_EB4F, 2'd1, "R5 window mix", "R3");

    wr(12'h300, 64'h0000_0000_0000_6000, 2'd3, "R5", "R4 fp state only");
    wr(12'h300, 64'h0000_0000_0001_8000, 2'd3, "R5", "R4 ext state only");
    wr(12'h300, 64'h8000_0000_0000_2000, 2'd3, "R5", "R4 not dirty");
    wr(12'h100, 64'h8000_0000_0001_0000, 2'd3, "R5", "R4 window");

    for (int a = 1; a <= 3; a++)
      for (int k = 0; k < 8; k++) begin
        wr(12'h300, 64'h0, 2'd3, "R9 clear", "R9");
        wr(12'(a), 64'(k * 419 + a * 37), 2'(k % 4), "R9 no flush", "R9");
      end

    wr(12'h300, 64'h0, 2'd3, "R8 setup", "R2");
    for (int p = 0; p < 4; p++)
      for (int t = 0; t < 2; t++) begin
        wr(12'h300, 64'(t) << 20, 2'd3, "R8 tvm", "R2");
        rd_ill(2'(p), (p == 1) && (t == 1));
        for (int m = 0; m < 16; m++) begin
          logic [63:0] d;
          d = (64'(m) << 60) | 64'h0FFF_F000_0000_0000 | 64'(m * 37 + p * 5 + t + 1);
          wr(12'h180, d, 2'(p), "R7 mode", "R6");
          wr(12'h180, d, 2'(p), "R7 equal", "R6");
        end
      end

    wr(12'h300, 64'h0, 2'd3, "R5", "R2");
    set_width(2'd1);
    wr(12'h300, 64'h0000_0003_0000_0000, 2'd3, "R5", "R2 width locked");
    for (int k = 0; k < 8; k++)
      wr(12'h180, 64'hFFFF_FFFF_FFFF_FFFF ^ (64'(k) << 29) ^ 64'(k * 1234567), 2'd3, "R10 narrow", "R6");
    set_width(2'd2);
    wr(12'h180, 64'h9000_0000_0000_0042, 2'd3, "R7 back to wide", "R6");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule